// File: doc/BRIEF.md
# Fast Reset and A20 Control Port

This block is a byte-wide system control register that sits at one I/O address (92h by default) on a simple register bus. Software uses it for two things. It can restart the processor quickly by writing a 1 to bit 0, which produces a fixed-length active-low reset pulse. It can also set the address-bit-20 mask enable by writing bit 1, which drives a steady control level.

The reset bit is edge-armed. A pulse fires only when bit 0 changes from 0 to 1. Writing 1 again while the bit already holds 1 does nothing. Software must clear the bit before it can fire another pulse. A bus reset ends any pulse at once, clears both stored bits and drives the A20 level low.

Top module: `fast_reset_a20_port`

## Requirements
- R1: After bus reset the reset output `cpu_rst_n` is 1, `a20_en` is 0, and a read of the port returns 00h.
- R2: A write to the port with data bit 0 = 1, while the stored bit 0 is 0, drives `cpu_rst_n` low from the clock edge that takes the write, for exactly PULSE_CLKS (default 4) clock cycles, and then high again.
- R3: A write with data bit 0 = 1 while the stored bit 0 is already 1 leaves `cpu_rst_n` unchanged.
- R4: After bit 0 has been written to 0, a later write of 1 to bit 0 fires a new pulse.
- R5: `a20_en` takes the value of data bit 1 of every port write, from the clock edge that takes the write.
- R6: While `rd_en` is high and the address matches, `rdata` shows {6'b0, a20 bit in position 1, reset bit in position 0} in the same cycle. Otherwise `rdata` is 00h. Data bits 7..2 are never stored.
- R7: Writes to any other address change neither the stored bits nor the outputs. With full decode, every address bit is compared.
- R8: A bus reset during a pulse drives `cpu_rst_n` high at once and clears bit 0, so the next write of 1 fires a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low bus reset, asynchronous |
| addr | input | ADDR_W (16) | I/O address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| wdata | input | DATA_W (8) | Write data |
| rdata | output | DATA_W (8) | Read data, combinational |
| cpu_rst_n | output | 1 | Active-low processor reset pulse |
| a20_en | output | 1 | A20 mask control level |

## Verification
Stored bits and `a20_en` change at the clock edge that takes the write, so the bench samples them at the falling edge just after that edge. `cpu_rst_n` falls at that same edge and stays low for PULSE_CLKS edges. The bench therefore counts the low samples over six consecutive falling edges, starting with the one after the write, and expects exactly four or none. Read data is combinational, so it is sampled 1 ns after the read strobe rises, inside the same cycle. A bus reset acts asynchronously, so the outputs are checked 1 ns after `rst_n` falls.

// File: rtl/fra_pkg.sv
package fra_pkg;
   localparam int BIT_RST = 0;
   localparam int BIT_A20 = 1;
   localparam int NUM_CTL = 2;

   typedef struct packed {
      logic a20;
      logic rst;
   } ctl_bits_t;
endpackage

// File: rtl/fra_match.sv
module fra_match #(
   parameter int          ADDR_W      = 16,
   parameter logic [15:0] PORT_ADDR   = 16'h0092,
   parameter bit          FULL_DECODE = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int LOW_W = (ADDR_W < 8) ? ADDR_W : 8;

   if (ADDR_W < 8) begin : g_bad_width
      $error("fra_match: ADDR_W must be at least 8");
   end

   if (FULL_DECODE) begin : g_full
      assign hit = (addr == ADDR_W'(PORT_ADDR));
   end else begin : g_alias
      logic unused_hi;
      assign unused_hi = ^addr;
      assign hit = (addr[LOW_W-1:0] == PORT_ADDR[LOW_W-1:0]);
   end
endmodule

// File: rtl/fra_ctl_bits.sv
module fra_ctl_bits
   import fra_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output ctl_bits_t         bits,
   output logic              fire
);
   logic [NUM_CTL-1:0] q;
   logic               unused_upper;

   if (DATA_W < NUM_CTL + 1) begin : g_bad_width
      $error("fra_ctl_bits: DATA_W too narrow");
   end

   for (genvar i = 0; i < NUM_CTL; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  q[i] <= 1'b0;
         else if (we) q[i] <= wdata[i];
      end
   end

   assign unused_upper = ^wdata[DATA_W-1:NUM_CTL];
   assign bits.rst     = q[BIT_RST];
   assign bits.a20     = q[BIT_A20];
   // arm edge: stored 0, incoming 1
   assign fire = we & wdata[BIT_RST] & ~q[BIT_RST];

   AST_FIRE_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> bits.rst);  // R4
endmodule

// File: rtl/fra_pulse.sv
module fra_pulse #(
   parameter int PULSE_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse_n
);
   localparam int CNT_W = $clog2(PULSE_CLKS + 1);

   if (PULSE_CLKS < 1) begin : g_bad_len
      $error("fra_pulse: PULSE_CLKS must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (fire)       cnt <= CNT_W'(PULSE_CLKS);
      else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
   end

   assign pulse_n = (cnt == '0);

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(PULSE_CLKS));  // R2
endmodule

// File: rtl/fra_rd_mux.sv
module fra_rd_mux
   import fra_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              sel,
   input  ctl_bits_t         bits,
   output logic [DATA_W-1:0] rdata
);
   logic [NUM_CTL-1:0] src;
   assign src = {bits.a20, bits.rst};

   for (genvar i = 0; i < DATA_W; i++) begin : g_lane
      if (i < NUM_CTL) begin : g_live
         assign rdata[i] = sel & src[i];
      end else begin : g_zero
         assign rdata[i] = 1'b0;
      end
   end
endmodule

// File: rtl/fast_reset_a20_port.sv
module fast_reset_a20_port
   import fra_pkg::*;
#(
   parameter int          ADDR_W      = 16,
   parameter int          DATA_W      = 8,
   parameter logic [15:0] PORT_ADDR   = 16'h0092,
   parameter bit          FULL_DECODE = 1'b1,
   parameter int          PULSE_CLKS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              cpu_rst_n,
   output logic              a20_en
);
   localparam int RUN_W = $clog2(PULSE_CLKS + 1) + 1;

   logic      hit, fire;
   ctl_bits_t bits;

   fra_match #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR), .FULL_DECODE(FULL_DECODE))
      u_match (.addr(addr), .hit(hit));

   fra_ctl_bits #(.DATA_W(DATA_W))
      u_bits (.clk(clk), .rst_n(rst_n), .we(wr_en & hit), .wdata(wdata),
              .bits(bits), .fire(fire));

   fra_pulse #(.PULSE_CLKS(PULSE_CLKS))
      u_pulse (.clk(clk), .rst_n(rst_n), .fire(fire), .pulse_n(cpu_rst_n));

   fra_rd_mux #(.DATA_W(DATA_W))
      u_rd (.sel(rd_en & hit), .bits(bits), .rdata(rdata));

   assign a20_en = bits.a20;

   // consecutive-low counter for pulse-length checking
   logic [RUN_W-1:0] low_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          low_run <= '0;
      else if (fire)       low_run <= '0;
      else if (!cpu_rst_n) low_run <= low_run + RUN_W'(1);
      else                 low_run <= '0;
   end

   AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit && wdata[BIT_RST] && !bits.rst) |=> !cpu_rst_n);  // R2
   AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      low_run <= RUN_W'(PULSE_CLKS));  // R2
   AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cpu_rst_n) && !$past(fire)) |-> low_run == RUN_W'(PULSE_CLKS));  // R2
   AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rst_n && !(wr_en && hit && wdata[BIT_RST] && !bits.rst)) |=> cpu_rst_n);  // R3
   AST_A20_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit) |=> a20_en == $past(wdata[BIT_A20]));  // R5
   AST_IGNORE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && hit) |=> ($stable(a20_en) && $stable(bits.rst)));  // R7
   AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && hit) |-> rdata == '0);  // R6
   AST_RST_CLEAN: assert property (@(posedge clk)
      $rose(rst_n) |-> (cpu_rst_n && !a20_en && !bits.rst));  // R1
   AST_RST_ABORT: assert property (@(posedge clk)
      !rst_n |-> cpu_rst_n);  // R8
endmodule

// File: tb/tb_fast_reset_a20_port.sv
`timescale 1ns/1ps
module tb_fast_reset_a20_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        cpu_rst_n;
   logic        a20_en;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   fast_reset_a20_port dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .cpu_rst_n(cpu_rst_n), .a20_en(a20_en));

   // fields: addr[39:24] wdata[23:16] exp_rd[15:8] exp_lows[7:0]
   localparam logic [39:0] VEC [8] = '{
      {16'h0092, 8'h02, 8'h02, 8'd0},   // R5 set A20, no pulse
      {16'h0092, 8'h03, 8'h03, 8'd4},   // R2 arm fires
      {16'h0092, 8'h03, 8'h03, 8'd0},   // R3 already armed
      {16'h0093, 8'h00, 8'h03, 8'd0},   // R7 other address
      {16'h0092, 8'hFC, 8'h00, 8'd0},   // R6 upper bits dropped
      {16'h0092, 8'h01, 8'h01, 8'd4},   // R4 re-armed
      {16'h1092, 8'h00, 8'h01, 8'd0},   // R7 full decode
      {16'h0092, 8'h00, 8'h00, 8'd0}    // R5 clear A20
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_rd(input logic [15:0] a, output logic [7:0] v);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 v = rdata;
      rd_en = 1'b0;
   endtask

   // called right after do_wr: samples at six falling edges
   task automatic count_lows(output int lows);
      lows = 0;
      for (int k = 0; k < 6; k++) begin
         if (k != 0) @(negedge clk);
         if (!cpu_rst_n) lows++;
      end
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int lows;
      repeat (3) @(negedge clk);
      check("R1 cpu_rst_n in reset", cpu_rst_n, 1);
      check("R1 a20_en in reset", a20_en, 0);
      rst_n = 1'b1;
      do_rd(16'h0092, v);
      check("R1 read after reset", v, 8'h00);

      for (int i = 0; i < 8; i++) begin
         do_wr(VEC[i][39:24], VEC[i][23:16]);
         check($sformatf("R5/R7 vec%0d a20_en", i), a20_en, VEC[i][9]);
         count_lows(lows);
         check($sformatf("R2/R3/R4 vec%0d pulse cycles", i), lows, VEC[i][7:0]);
         do_rd(16'h0092, v);
         check($sformatf("R6/R7 vec%0d readback", i), v, VEC[i][15:8]);
      end

      // R6: no strobe or wrong address reads zero
      do_wr(16'h0092, 8'h02);
      do_rd(16'h0091, v);
      check("R6 read other address", v, 8'h00);
      @(negedge clk); addr = 16'h0092; #1;
      check("R6 rdata without rd_en", rdata, 8'h00);

      // R8: reset mid-pulse
      do_wr(16'h0092, 8'h03);
      check("R2 pulse began", cpu_rst_n, 0);
      @(negedge clk);
      rst_n = 1'b0; #1;
      check("R8 pulse aborted", cpu_rst_n, 1);
      check("R8 a20 cleared", a20_en, 0);
      @(negedge clk);
      rst_n = 1'b1;
      do_rd(16'h0092, v);
      check("R8 bits cleared", v, 8'h00);
      do_wr(16'h0092, 8'h01);
      count_lows(lows);
      check("R8 re-armed after reset", lows, 4);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule